// File: doc/BRIEF.md
# Two-wire Serial Configuration Register Bank

This block is a target-only two-wire serial port (SMBus/I²C style) in front of three 8-bit control registers. The host drives the clock and data lines. The block samples both lines through synchronisers, runs in the system clock domain, and detects start, repeated start and stop conditions. It pulls the data line low through a separate drive-low output, which goes to an open-drain pad.

A transfer begins with a 7-bit address. The upper four bits of that address are fixed. The lower three bits come from strap pins. After the address the host sends one command byte, which selects one of two access modes:

- **Indexed block access.** The command byte is 0x00. Access starts at register 0.
- **Single-byte access.** Bit 7 of the command byte is set. The low seven bits of the command byte give the register offset.

Register contents are driven out continuously as parallel control bits: output enables, ratio selects, a fan-out/PLL select, a bandwidth select and a power-down drive select. Some reset values come from a frequency strap that is sampled while reset is held.

Top module: `smbcfg_bank`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {ADDR_HI, strap_sa_i}. With the default ADDR_HI = 4'b1101 and strap 3'b101, the write address byte is 0xDA and the read address byte is 0xDB. After a non-matching address, the block acknowledges no further byte and changes no register until the next start.
- R2: A command byte with bit 7 set selects single-byte mode, and bits [6:0] give the offset. The next data byte is acknowledged and written to that offset. A command byte that is neither 0x00 nor 1xxxxxxx is not acknowledged.
- R3: Command 0x00 followed by a count byte N starts a block write. The next N data bytes go to registers 0, 1, 2 and so on, and each is acknowledged. Any byte beyond N is not acknowledged and is discarded.
- R4: Block read uses command 0x00, then a repeated start with the read address. The block returns the count 0x03 first, then registers 0, 1, 2 in that order.
- R5: Random read uses a single-byte command, then a repeated start with the read address. The block returns the register at the offset given in the command.
- R6: Reset values. Register 1 = 0xFF. Register 2 = 0xFF. Register 0 bits 0, 5, 6 and 7 = 1, and register 0 bit 2 = 0.
- R7: While reset is held, the frequency strap fs is sampled into register 0. Bit 1 takes ~fs, bit 3 takes fs, and bit 4 takes fs.
- R8: Offsets 3 and above read back as 0x00. A write to such an offset is acknowledged but discarded. Reserved bits (register 0 bit 5 and register 2 bit 4) read back their written value and appear on spare_o.
- R9: sda_drive_low_o changes only while SCL is low. The block drives its acknowledge during the ninth clock of each byte it accepts.
- R10: A start or stop that arrives in the middle of a byte ends the transfer, releases SDA and returns the engine to address reception or idle. The partial byte writes nothing.
- R11: The output pins map to register bits as follows:
  - out_en_o = {reg2[3:0], reg1}
  - gear_sel_o = reg0[3:0]
  - fs_latched_o = reg0[4]
  - pair_one2one_o = reg0[6]
  - ten_one2one_o = reg0[7]
  - pll_mode_o = reg2[5]
  - low_bw_o = reg2[6]
  - pd_drive_o = reg2[7]

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used for sampling and all state |
| rst_n | input | 1 | Synchronous active-low reset; the fs strap is sampled while it is low |
| scl_i | input | 1 | Serial clock line, sampled from the pad |
| sda_i | input | 1 | Serial data line, sampled from the pad |
| sda_drive_low_o | output | 1 | 1 = pull the data line low |
| strap_sa_i | input | 3 | Low three address bits |
| strap_fs_i | input | 1 | Frequency strap that sets reset values in register 0 |
| out_en_o | output | 12 | Output enables (1 = enabled, 0 = high impedance) |
| gear_sel_o | output | 4 | Gear ratio code |
| fs_latched_o | output | 1 | Register copy of the frequency strap |
| pair_one2one_o | output | 1 | Two-output group: 1 = 1:1, 0 = geared |
| ten_one2one_o | output | 1 | Ten-output group: 1 = 1:1, 0 = geared |
| pll_mode_o | output | 1 | 1 = PLL, 0 = fan-out bypass |
| low_bw_o | output | 1 | 1 = low bandwidth, 0 = high bandwidth |
| pd_drive_o | output | 1 | Output current during power down: 1 = 2×reference, 0 = high impedance |
| spare_o | output | 2 | Reserved storage bits {reg2[4], reg0[5]} |

## Verification
The bench builds the block with its default parameters: ADDR_HI = 4'b1101 and a two-stage synchroniser. The address straps are tied to 3'b101, so address bytes 0xDA and 0xDB are accepted and 0xD0 is refused. Running reset once with fs = 1 and once with fs = 0 covers both strap-derived patterns in register 0. Because the default bank has exactly three registers, offset 5 falls outside the bank and the block-read count is 0x03. The bench therefore checks both out-of-range handling and the count byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } smb_phase_e;

  // Reset value of register idx; fs is the frequency strap seen during reset.
  function automatic logic [7:0] reg_reset_value(int idx, logic fs);
    case (idx)
      0:       return {3'b111, fs, fs, 1'b0, ~fs, 1'b1};
      1:       return 8'hFF;
      2:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_cfg_pkg::*; #(
  parameter int NUM_REGS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_fs,
  input  logic                  wr_en,
  input  logic [6:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic [7:0] r_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        r_q[g] <= reg_reset_value(g, strap_fs);
      else if (wr_en && wr_addr == 7'(g))
        r_q[g] <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = r_q[g];
  end

  // Offsets outside the bank read back as zero.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == 7'(i)) rd_data = r_q[i];
  end
endmodule

// File: rtl/smb_engine.sv
module smb_engine import smb_cfg_pkg::*; #(
  parameter logic [3:0] ADDR_HI  = 4'b1101,
  parameter int         NUM_REGS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_sa,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [6:0] ptr,
  output logic       wr_en,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_low
);
  localparam logic [3:0] ACK_SLOT   = 4'd8;
  localparam logic [3:0] AFTER_ACK  = 4'd9;
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  smb_phase_e phase, nxt;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, txreg, remain, tx_byte;
  logic       blk, send_cnt;

  assign tx_byte = send_cnt ? COUNT_BYTE : rd_data;
  assign wr_data = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  nxt <= PH_IDLE;  bit_cnt <= '0;
      shreg <= '0;  txreg <= '0;  remain <= '0;
      blk <= 1'b0;  send_cnt <= 1'b0;  ptr <= '0;
      wr_en <= 1'b0;  wr_addr <= '0;  sda_low <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase <= PH_ADDR;  bit_cnt <= '0;  sda_low <= 1'b0;
      end else if (stop_det) begin
        phase <= PH_IDLE;  bit_cnt <= '0;  sda_low <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_SKIP) begin
        if (scl_rise) begin
          if (phase == PH_RDATA) begin
            if (bit_cnt < ACK_SLOT) bit_cnt <= bit_cnt + 4'd1;
            else if (sda_s)         phase <= PH_SKIP;   // host NACK
          end else if (bit_cnt < ACK_SLOT) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
        end else if (scl_fall) begin
          if (bit_cnt == ACK_SLOT) begin
            bit_cnt <= AFTER_ACK;
            if (phase == PH_RDATA) sda_low <= 1'b0;
            else begin
              case (phase)
                PH_ADDR:
                  if (shreg[7:1] == {ADDR_HI, strap_sa}) begin
                    sda_low <= 1'b1;
                    if (shreg[0]) begin nxt <= PH_RDATA; send_cnt <= blk; end
                    else          nxt <= PH_CMD;
                  end else phase <= PH_SKIP;
                PH_CMD:
                  if (shreg == 8'h00) begin
                    sda_low <= 1'b1;  blk <= 1'b1;  ptr <= '0;
                    remain <= '0;  nxt <= PH_COUNT;
                  end else if (shreg[7]) begin
                    sda_low <= 1'b1;  blk <= 1'b0;  ptr <= shreg[6:0];
                    remain <= 8'd1;  nxt <= PH_WDATA;
                  end else phase <= PH_SKIP;
                PH_COUNT: begin
                  sda_low <= 1'b1;  remain <= shreg;  nxt <= PH_WDATA;
                end
                PH_WDATA:
                  if (remain != 8'd0) begin
                    sda_low <= 1'b1;  wr_en <= 1'b1;  wr_addr <= ptr;
                    ptr <= ptr + 7'd1;  remain <= remain - 8'd1;  nxt <= PH_WDATA;
                  end else phase <= PH_SKIP;
                default: phase <= PH_SKIP;
              endcase
            end
          end else if (bit_cnt == AFTER_ACK) begin
            bit_cnt <= '0;
            phase   <= nxt;
            sda_low <= 1'b0;
            if (nxt == PH_RDATA) begin
              txreg    <= tx_byte;
              sda_low  <= ~tx_byte[7];
              send_cnt <= 1'b0;
              if (!send_cnt) ptr <= ptr + 7'd1;
            end
          end else if (phase == PH_RDATA) begin
            sda_low <= ~txreg[3'd7 - bit_cnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/smbcfg_bank.sv
module smbcfg_bank #(
  parameter logic [3:0] ADDR_HI     = 4'b1101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_drive_low_o,
  input  logic [2:0]  strap_sa_i,
  input  logic        strap_fs_i,
  output logic [11:0] out_en_o,
  output logic [3:0]  gear_sel_o,
  output logic        fs_latched_o,
  output logic        pair_one2one_o,
  output logic        ten_one2one_o,
  output logic        pll_mode_o,
  output logic        low_bw_o,
  output logic        pd_drive_o,
  output logic [1:0]  spare_o
);
  localparam int NUM_REGS = 3;

  logic scl_sync, sda_sync, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [6:0] wr_addr, acc_ptr;
  logic [7:0] wr_data, rd_data;
  logic [NUM_REGS*8-1:0] regs_flat;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_sync), .sda_s(sda_sync), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  smb_engine #(.ADDR_HI(ADDR_HI), .NUM_REGS(NUM_REGS)) u_engine (
    .clk(clk), .rst_n(rst_n), .strap_sa(strap_sa_i), .sda_s(sda_sync),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(acc_ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_low(sda_drive_low_o)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(acc_ptr),
    .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign out_en_o       = {regs_flat[19:16], regs_flat[15:8]};
  assign gear_sel_o     = regs_flat[3:0];
  assign fs_latched_o   = regs_flat[4];
  assign pair_one2one_o = regs_flat[6];
  assign ten_one2one_o  = regs_flat[7];
  assign pll_mode_o     = regs_flat[21];
  assign low_bw_o       = regs_flat[22];
  assign pd_drive_o     = regs_flat[23];
  assign spare_o        = {regs_flat[20], regs_flat[5]};
endmodule

// File: rtl/smbcfg_bank_chk.sv
module smbcfg_bank_chk #(
  parameter int NUM_REGS = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_sync,
  input logic        sda_drive_low_o,
  input logic        start_det,
  input logic        stop_det,
  input logic        wr_en,
  input logic [6:0]  wr_addr,
  input logic [11:0] out_en_o,
  input logic [3:0]  gear_sel_o,
  input logic        pll_mode_o,
  input logic        low_bw_o,
  input logic        pd_drive_o
);
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low_o) |-> !$past(scl_sync));

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_drive_low_o);

  a_r10_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_drive_low_o);

  a_r8_far_write_void: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=>
      ($stable(out_en_o) && $stable(gear_sel_o) && $stable(pll_mode_o)));

  a_r6_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_en_o == 12'hFFF && pll_mode_o && low_bw_o && pd_drive_o));

  a_r7_fs_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gear_sel_o[1] != gear_sel_o[3]));
endmodule

bind smbcfg_bank smbcfg_bank_chk #(.NUM_REGS(3)) u_chk (.*);

// File: tb/tb_smbcfg_bank.sv
module tb_smbcfg_bank;
  localparam int Q = 8;
  localparam logic [7:0] WA = 8'hDA, RA = 8'hDB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, fs = 1'b1;
  logic [2:0] sa = 3'b101;
  logic dut_low;
  logic [11:0] out_en;
  logic [3:0] gear;
  logic fs_l, pair1, ten1, pll, lbw, pdd;
  logic [1:0] spare;
  wire sda_line = ~(m_low | dut_low);

  smbcfg_bank dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low_o(dut_low), .strap_sa_i(sa), .strap_fs_i(fs),
    .out_en_o(out_en), .gear_sel_o(gear), .fs_latched_o(fs_l),
    .pair_one2one_o(pair1), .ten_one2one_o(ten1), .pll_mode_o(pll),
    .low_bw_o(lbw), .pd_drive_o(pdd), .spare_o(spare)
  );

  int n_cmp = 0, n_bad = 0, r9_bad = 0;
  bit done = 0;
  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R9 monitor: the slave drive may only move while SCL is low
  logic prev_low = 1'b0;
  always @(posedge clk) begin
    if (rst_n && dut_low != prev_low && scl) r9_bad++;
    prev_low <= dut_low;
  end

  // scoreboard monitor
  initial begin
    forever begin
      wait (got_q.size() > 0);
      begin
        item_t it;
        logic [7:0] g;
        it = exp_q.pop_front();
        g  = got_q.pop_front();
        check(it.tag, {24'h0, g}, {24'h0, it.val});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic send_bit(logic b);
    m_low = ~b; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(2);
  endtask

  task automatic start_c();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
  endtask

  task automatic write_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2); scl = 1'b0; tick(2);
  endtask

  task automatic read_byte(logic give_ack);
    logic [7:0] b;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q/2); b[i] = sda_line; tick(Q/2); scl = 1'b0; tick(2);
    end
    got_q.push_back(b);
    send_bit(~give_ack);
    m_low = 1'b0;
  endtask

  task automatic wr_reg(logic [6:0] off, logic [7:0] d, string tag);
    logic a;
    start_c();
    write_byte(WA, a);            check({tag, " addr ack"}, a, 1);
    write_byte({1'b1, off}, a);   check({tag, " cmd ack"}, a, 1);
    write_byte(d, a);             check({tag, " data ack"}, a, 1);
    stop_c();
  endtask

  task automatic rd_reg(logic [6:0] off, logic [7:0] e, string tag);
    logic a;
    exp_q.push_back('{tag, e});
    start_c();
    write_byte(WA, a);            check({tag, " addr ack"}, a, 1);
    write_byte({1'b1, off}, a);   check({tag, " cmd ack"}, a, 1);
    start_c();
    write_byte(RA, a);            check({tag, " read addr ack"}, a, 1);
    read_byte(1'b0);
    stop_c();
  endtask

  initial begin
    logic a;
    tick(5); rst_n = 1'b1; tick(3);
    check("R6 out_en reset", out_en, 12'hFFF);
    check("R6 pll/bw/pd reset", {pll, lbw, pdd}, 3'b111);
    check("R6 group ratio reset", {pair1, ten1}, 2'b11);
    check("R7 gear reset fs=1", gear, 4'b1001);
    check("R7 fs latched fs=1", fs_l, 1);
    check("R9 idle release", dut_low, 0);

    wr_reg(7'd1, 8'h5A, "R2 byte write");
    check("R2 R11 out_en after write", out_en, 12'hF5A);
    rd_reg(7'd1, 8'h5A, "R5 random read reg1");

    // R1: wrong address, everything ignored
    start_c();
    write_byte(8'hD0, a);  check("R1 foreign addr nack", a, 0);
    write_byte(8'h81, a);  check("R1 byte after nack ignored", a, 0);
    write_byte(8'h00, a);  check("R1 data after nack ignored", a, 0);
    stop_c();
    check("R1 no register change", out_en, 12'hF5A);

    // R2: unsupported command
    start_c();
    write_byte(WA, a);     check("R2 addr ack", a, 1);
    write_byte(8'h40, a);  check("R2 unsupported cmd nack", a, 0);
    stop_c();

    // R3: block write with count 3, then one extra byte
    start_c();
    write_byte(WA, a);     check("R3 addr ack", a, 1);
    write_byte(8'h00, a);  check("R3 block cmd ack", a, 1);
    write_byte(8'h03, a);  check("R3 count ack", a, 1);
    write_byte(8'hA5, a);  check("R3 data0 ack", a, 1);
    write_byte(8'h3C, a);  check("R3 data1 ack", a, 1);
    write_byte(8'h1E, a);  check("R3 data2 ack", a, 1);
    write_byte(8'h99, a);  check("R3 excess byte nack", a, 0);
    stop_c();
    check("R3 R11 out_en", out_en, 12'hE3C);
    check("R3 R11 gear", gear, 4'h5);
    check("R11 reg0 upper bits", {ten1, pair1, fs_l}, 3'b100);
    check("R11 reg2 controls", {pdd, lbw, pll}, 3'b000);
    check("R8 spare bits", spare, 2'b11);

    // R4: block read
    exp_q.push_back('{"R4 count byte", 8'h03});
    exp_q.push_back('{"R4 reg0", 8'hA5});
    exp_q.push_back('{"R4 reg1", 8'h3C});
    exp_q.push_back('{"R4 reg2", 8'h1E});
    start_c();
    write_byte(WA, a);     check("R4 addr ack", a, 1);
    write_byte(8'h00, a);  check("R4 cmd ack", a, 1);
    start_c();
    write_byte(RA, a);     check("R4 read addr ack", a, 1);
    read_byte(1'b1); read_byte(1'b1); read_byte(1'b1); read_byte(1'b0);
    stop_c();

    // R8: out of range and reserved bits
    wr_reg(7'd5, 8'h77, "R8 far write");
    check("R8 far write discarded", out_en, 12'hE3C);
    rd_reg(7'd5, 8'h00, "R8 far read zero");
    wr_reg(7'd0, 8'h5F, "R8 reg0 write");
    rd_reg(7'd0, 8'h5F, "R8 reserved readback");
    check("R8 spare after clear", spare, 2'b10);

    // R10: stop mid-byte
    start_c();
    write_byte(WA, a);     check("R10 addr ack", a, 1);
    send_bit(1); send_bit(0); send_bit(0);
    stop_c();
    check("R10 sda released after stop", dut_low, 0);
    rd_reg(7'd1, 8'h3C, "R10 engine usable after stop");

    // R10: start mid data byte
    start_c();
    write_byte(WA, a);     check("R10 addr2 ack", a, 1);
    write_byte(8'h81, a);  check("R10 cmd2 ack", a, 1);
    send_bit(0); send_bit(0); send_bit(0); send_bit(0);
    start_c();
    write_byte(WA, a);     check("R10 restart addr ack", a, 1);
    write_byte(8'h81, a);  check("R10 restart cmd ack", a, 1);
    write_byte(8'h11, a);  check("R10 restart data ack", a, 1);
    stop_c();
    check("R10 only full byte written", out_en, 12'hE11);

    // R7: reset with the other strap value
    rst_n = 1'b0; fs = 1'b0; tick(4); rst_n = 1'b1; tick(3);
    check("R7 gear reset fs=0", gear, 4'b0011);
    check("R7 fs latched fs=0", fs_l, 0);
    check("R6 out_en second reset", out_en, 12'hFFF);

    wait (exp_q.size() == 0 && got_q.size() == 0);
    tick(4);
    check("R9 no drive change while SCL high", r9_bad, 0);
    finish_run();
  end
endmodule